// File: doc/BRIEF.md
# Bytecode-to-Native Instruction Generator

This block sits in the instruction-fetch path of a host processor. To the host it looks like instruction memory. It acts as a bus master on shared memory and reads a compact intermediate program one byte at a time. Each 8-bit opcode is looked up in a programmable decode table. The table entry says how many literal operand bytes follow the opcode and which run of native words in a template store makes up its translation. The host then reads those native words one per fetch, and the operand is written into every word that is marked for it. A host that only reads its instruction bus therefore runs the intermediate program directly, and each native word crosses that bus once.

A four-entry queue of decoded opcodes lets memory fetch and decode run ahead of host execution. The emitted order always matches the order of the intermediate program. An intermediate-level jump is made by a host write that loads a new intermediate program counter. That write throws away everything fetched ahead and everything still waiting to be emitted. Loading new decode and template contents retargets the block to another intermediate language.

Top module: `bcx_xlate_top`

## Requirements
- R1: After reset no host fetch is answered (`hst_ready` low), the queue is empty, and the first memory request reads address 0.
- R2: `hst_ready` rises only while `hst_rd_en` is high and a native word is available. Otherwise the host fetch waits with `hst_ready` low.
- R3: A decode entry is written at `cfg_addr` = opcode with `cfg_sel`=0. Its bits [5:0] hold the template start index, bits [9:6] the word count and bits [11:10] the operand byte count. The host receives that many template words, from the start index upward, one per completed fetch.
- R4: The operand byte count is 0, 1 or 2 (code 3 acts as 2). The bytes are read from the addresses right after the opcode. The first byte forms operand bits [7:0] and the second forms bits [15:8]; missing bytes are zero.
- R5: A template word is written with `cfg_sel`=1 at `cfg_addr[5:0]`, with the word in `cfg_wdata[31:0]` and the operand flag in `cfg_wdata[32]`. When the flag is set, bits [15:0] of the emitted word are replaced by the 16-bit operand. Unflagged words pass unchanged.
- R6: Native sequences come out in the same order as their opcodes appear in the intermediate program.
- R7: At most five decoded opcodes are held ahead of the host: four queued and one being emitted. When that limit is reached, `mem_req` stays low until the host consumes words.
- R8: A cycle with `ctl_we` high loads `ctl_pc` as the new intermediate address. It discards queued entries and the rest of the sequence being emitted. The next memory request reads `ctl_pc`.
- R9: An opcode whose word count is 0 emits nothing, and the next opcode's sequence follows directly.
- R10: Template indices wrap modulo 64, so a sequence may run from the top of the template store into index 0.
- R11: While `mem_req` is high and `mem_ack` low, `mem_addr` and `mem_req` hold steady, unless a jump occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_rd_en | input | 1 | Host instruction fetch request, held until answered |
| hst_ready | output | 1 | Fetch answered this cycle |
| hst_rdata | output | 32 | Native instruction word |
| ctl_we | input | 1 | Load new intermediate address (jump) |
| ctl_pc | input | 16 | New intermediate address |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 selects the decode table, 1 the template store |
| cfg_addr | input | 8 | Opcode, or template index in bits [5:0] |
| cfg_wdata | input | 33 | Decode entry or flagged template word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the read |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 8 | Read byte |

## Verification
The hardest condition to reach is a full prefetch store while the host is idle, because the host normally drains words as fast as they appear. The bench reaches it with a jump into a run of operand-free opcodes and then holds `hst_rd_en` low. It counts completed memory handshakes until the request line drops and expects exactly five. A jump that hits a partly emitted sequence is reached by reading only the first word of a two-word translation before loading the new address. Wait states are reached by holding memory acknowledge low while the host keeps requesting.

// File: rtl/bcx_pkg.sv
package bcx_pkg;
  localparam int OPC_W      = 8;
  localparam int WORD_W     = 32;
  localparam int OPER_W     = 16;
  localparam int TMPL_AW    = 6;
  localparam int LEN_W      = 4;
  localparam int NOPS_W     = 2;
  localparam int TMPL_DEPTH = 1 << TMPL_AW;
  localparam int OPC_COUNT  = 1 << OPC_W;
  localparam int DEC_W      = NOPS_W + LEN_W + TMPL_AW;

  typedef struct packed {
    logic [NOPS_W-1:0]  nops;
    logic [LEN_W-1:0]   len;
    logic [TMPL_AW-1:0] start;
  } dec_t;

  typedef struct packed {
    logic [TMPL_AW-1:0] start;
    logic [LEN_W-1:0]   len;
    logic [OPER_W-1:0]  oper;
  } qent_t;

  localparam int QENT_W = TMPL_AW + LEN_W + OPER_W;

  // operand byte count; code 3 behaves as 2
  function automatic logic [1:0] oper_bytes(input logic [NOPS_W-1:0] code);
    return (code > 2'd2) ? 2'd2 : code;
  endfunction

  function automatic logic [TMPL_AW-1:0] tmpl_index(input logic [TMPL_AW-1:0] start,
                                                    input logic [LEN_W-1:0] idx);
    logic [TMPL_AW-1:0] ext;
    ext = TMPL_AW'(idx);
    return start + ext;
  endfunction

  function automatic logic [WORD_W-1:0] splice_word(input logic [WORD_W-1:0] word,
                                                    input logic flag,
                                                    input logic [OPER_W-1:0] oper);
    return flag ? {word[WORD_W-1:OPER_W], oper} : word;
  endfunction
endpackage

// File: rtl/bcx_dectab.sv
module bcx_dectab
  import bcx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OPC_W-1:0] wr_opc,
  input  logic [DEC_W-1:0] wr_data,
  input  logic [OPC_W-1:0] rd_opc,
  output dec_t             rd_ent
);
  logic [DEC_W-1:0] tab [OPC_COUNT];

  generate
    for (genvar g = 0; g < OPC_COUNT; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) tab[g] <= '0;
        else if (wr_en && wr_opc == OPC_W'(g)) tab[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_ent = dec_t'(tab[rd_opc]);
endmodule

// File: rtl/bcx_tmpl.sv
module bcx_tmpl
  import bcx_pkg::*;
(
  input  logic               clk,
  input  logic               wr_en,
  input  logic [TMPL_AW-1:0] wr_idx,
  input  logic [WORD_W:0]    wr_data,
  input  logic [TMPL_AW-1:0] rd_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic               rd_flag
);
  logic [WORD_W:0] store [TMPL_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  assign rd_word = store[rd_idx][WORD_W-1:0];
  assign rd_flag = store[rd_idx][WORD_W];
endmodule

// File: rtl/bcx_queue.sv
module bcx_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = slots[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) slots[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);
endmodule

// File: rtl/bcx_fetcher.sv
module bcx_fetcher
  import bcx_pkg::*;
#(
  parameter int MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [MEM_AW-1:0] load_pc,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic [OPC_W-1:0]  dec_opc,
  input  dec_t              dec_ent,
  input  logic              q_full,
  output logic              q_push,
  output qent_t             q_wdata
);
  typedef enum logic [1:0] {F_OPC, F_B1, F_B2} fst_t;

  fst_t              st;
  logic [MEM_AW-1:0] pc;
  dec_t              ent;
  logic [7:0]        lo_byte;
  logic              ack_ok;
  logic              opc_done;
  logic [1:0]        ent_bytes;
  logic [1:0]        new_bytes;

  assign mem_req   = (st == F_OPC) ? !q_full : 1'b1;
  assign mem_addr  = pc;
  assign ack_ok    = mem_req && mem_ack && !flush;
  assign dec_opc   = mem_rdata;
  assign new_bytes = oper_bytes(dec_ent.nops);
  assign ent_bytes = oper_bytes(ent.nops);
  assign opc_done  = ack_ok && (st == F_OPC);

  always_comb begin
    q_push  = 1'b0;
    q_wdata = '0;
    if (ack_ok) begin
      unique case (st)
        F_OPC: if (new_bytes == 2'd0) begin
          q_push  = 1'b1;
          q_wdata = '{start: dec_ent.start, len: dec_ent.len, oper: '0};
        end
        F_B1: if (ent_bytes == 2'd1) begin
          q_push  = 1'b1;
          q_wdata = '{start: ent.start, len: ent.len, oper: {8'h00, mem_rdata}};
        end
        F_B2: begin
          q_push  = 1'b1;
          q_wdata = '{start: ent.start, len: ent.len, oper: {mem_rdata, lo_byte}};
        end
        default: q_push = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= F_OPC; pc <= '0; ent <= '0; lo_byte <= '0;
    end else if (flush) begin
      st <= F_OPC; pc <= load_pc;
    end else if (ack_ok) begin
      pc <= pc + 1'b1;
      unique case (st)
        F_OPC: begin
          ent <= dec_ent;
          if (new_bytes != 2'd0) st <= F_B1;
        end
        F_B1: begin
          lo_byte <= mem_rdata;
          st <= (ent_bytes == 2'd1) ? F_OPC : F_B2;
        end
        F_B2: st <= F_OPC;
        default: st <= F_OPC;
      endcase
    end
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !flush) |=> (mem_req && mem_addr == $past(mem_addr)));
  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mem_addr == $past(load_pc)));
  // R4
  operand_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && st == F_B2) |-> (q_push && q_wdata.oper[7:0] == lo_byte));
  // R3
  push_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (ack_ok && !opc_done) || (opc_done && new_bytes == 2'd0));
endmodule

// File: rtl/bcx_emitter.sv
module bcx_emitter
  import bcx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               q_empty,
  input  qent_t              q_rdata,
  output logic               q_pop,
  output logic [TMPL_AW-1:0] tmpl_idx,
  input  logic [WORD_W-1:0]  tmpl_word,
  input  logic               tmpl_flag,
  input  logic               hst_rd_en,
  output logic               hst_ready,
  output logic [WORD_W-1:0]  hst_rdata
);
  logic             act;
  qent_t            cur;
  logic [LEN_W-1:0] idx;
  logic             last_word;

  assign q_pop     = !act && !q_empty && !flush;
  assign tmpl_idx  = tmpl_index(cur.start, idx);
  assign hst_ready = act && hst_rd_en && !flush;
  assign last_word = (idx == cur.len - 1'b1);
  assign hst_rdata = splice_word(tmpl_word, tmpl_flag, cur.oper);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; cur <= '0; idx <= '0;
    end else if (flush) begin
      act <= 1'b0;
    end else if (q_pop) begin
      cur <= q_rdata;
      idx <= '0;
      act <= (q_rdata.len != '0);
    end else if (hst_ready) begin
      if (last_word) act <= 1'b0;
      else           idx <= idx + 1'b1;
    end
  end

  // R2
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ready |-> hst_rd_en);
  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (idx < cur.len));
  // R9
  empty_seq_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_rdata.len == '0) |=> !act);
endmodule

// File: rtl/bcx_xlate_top.sv
module bcx_xlate_top
  import bcx_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_rd_en,
  output logic              hst_ready,
  output logic [WORD_W-1:0] hst_rdata,
  input  logic              ctl_we,
  input  logic [MEM_AW-1:0] ctl_pc,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [OPC_W-1:0]  cfg_addr,
  input  logic [WORD_W:0]   cfg_wdata,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  logic               flush;
  logic [OPC_W-1:0]   dec_opc;
  dec_t               dec_ent;
  logic               q_push, q_pop, q_full, q_empty;
  qent_t              q_wdata, q_rdata;
  logic [QENT_W-1:0]  q_rbits;
  logic [TMPL_AW-1:0] tmpl_idx;
  logic [WORD_W-1:0]  tmpl_word;
  logic               tmpl_flag;

  assign flush   = ctl_we;
  assign q_rdata = qent_t'(q_rbits);

  bcx_dectab u_dectab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && !cfg_sel), .wr_opc(cfg_addr), .wr_data(cfg_wdata[DEC_W-1:0]),
    .rd_opc(dec_opc), .rd_ent(dec_ent)
  );

  bcx_tmpl u_tmpl (
    .clk(clk),
    .wr_en(cfg_we && cfg_sel), .wr_idx(cfg_addr[TMPL_AW-1:0]), .wr_data(cfg_wdata),
    .rd_idx(tmpl_idx), .rd_word(tmpl_word), .rd_flag(tmpl_flag)
  );

  bcx_fetcher #(.MEM_AW(MEM_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load_pc(ctl_pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dec_opc(dec_opc), .dec_ent(dec_ent),
    .q_full(q_full), .q_push(q_push), .q_wdata(q_wdata)
  );

  bcx_queue #(.DEPTH(QDEPTH), .W(QENT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(q_push), .wdata(q_wdata), .pop(q_pop), .rdata(q_rbits),
    .full(q_full), .empty(q_empty)
  );

  bcx_emitter u_emit (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .q_empty(q_empty), .q_rdata(q_rdata), .q_pop(q_pop),
    .tmpl_idx(tmpl_idx), .tmpl_word(tmpl_word), .tmpl_flag(tmpl_flag),
    .hst_rd_en(hst_rd_en), .hst_ready(hst_ready), .hst_rdata(hst_rdata)
  );

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_empty && !hst_ready));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (q_empty && !hst_ready && mem_addr == '0));
endmodule

// File: tb/bcx_xlate_top_tb_top.sv
module bcx_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_rd_en = 1'b0;
  logic        hst_ready;
  logic [31:0] hst_rdata;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_pc = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [32:0] cfg_wdata = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic        mem_stall = 1'b0;
  logic [7:0]  mem [256];
  int          ack_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          wd_hit = 1'b0;

  always #4 clk = ~clk;

  assign mem_ack   = mem_req && !mem_stall;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) if (mem_req && mem_ack) ack_cnt <= ack_cnt + 1;

  bcx_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n), .hst_rd_en(hst_rd_en), .hst_ready(hst_ready),
    .hst_rdata(hst_rdata), .ctl_we(ctl_we), .ctl_pc(ctl_pc), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_dec(input logic [7:0] opc, input int nops, input int len, input int start);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = opc;
    cfg_wdata = {21'd0, 2'(nops), 4'(len), 6'(start)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_tpl(input int idx, input bit flag, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 8'(idx); cfg_wdata = {flag, w};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic jump(input logic [15:0] pc);
    @(negedge clk);
    ctl_we = 1'b1; ctl_pc = pc;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic host_read(output logic [31:0] w, output bit got);
    got = 1'b0; w = '0;
    @(negedge clk);
    hst_rd_en = 1'b1;
    for (int k = 0; k < 200; k++) begin
      #1;
      if (hst_ready) begin
        w = hst_rdata; got = 1'b1;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    hst_rd_en = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [31:0] exp);
    logic [31:0] w;
    bit got;
    host_read(w, got);
    chk(got && w == exp, req, w, exp);
  endtask

  task automatic t_reset_state();
    #1;
    chk(hst_ready == 1'b0, "R1 ready", 32'(hst_ready), 32'd0);
    chk(mem_req == 1'b1, "R1 req", 32'(mem_req), 32'd1);
    chk(mem_addr == 16'd0, "R1 addr", 32'(mem_addr), 32'd0);
  endtask

  task automatic t_program();
    cfg_dec(8'h10, 0, 2, 0);
    cfg_dec(8'h11, 1, 1, 2);
    cfg_dec(8'h12, 2, 2, 3);
    cfg_dec(8'h13, 0, 0, 0);
    cfg_dec(8'h14, 0, 3, 62);
    cfg_dec(8'h15, 1, 1, 5);
    cfg_tpl(0, 1'b0, 32'hA000_0001);
    cfg_tpl(1, 1'b0, 32'hA000_0002);
    cfg_tpl(2, 1'b1, 32'hB123_0000);
    cfg_tpl(3, 1'b0, 32'hC000_0003);
    cfg_tpl(4, 1'b1, 32'hC444_0000);
    cfg_tpl(5, 1'b1, 32'hD555_9999);
    cfg_tpl(62, 1'b0, 32'hE000_003E);
    cfg_tpl(63, 1'b0, 32'hE000_003F);
  endtask

  // R2 and R11: host waits while memory stalls, address holds
  task automatic t_wait_states();
    bit seen_ready = 1'b0;
    bit addr_moved = 1'b0;
    logic [31:0] w;
    bit got;
    mem_stall = 1'b1;
    jump(16'h0000);
    hst_rd_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (hst_ready) seen_ready = 1'b1;
      if (mem_addr != 16'h0000 || !mem_req) addr_moved = 1'b1;
      @(negedge clk);
    end
    hst_rd_en = 1'b0;
    chk(!seen_ready, "R2 wait state", 32'(seen_ready), 32'd0);
    chk(!addr_moved, "R11 addr hold", 32'(mem_addr), 32'h0);
    mem_stall = 1'b0;
    host_read(w, got);
    chk(got && w == 32'hA000_0001, "R2 answered after stall", w, 32'hA000_0001);
  endtask

  // R3 R4 R5 R6 R9 R10: full program in order
  task automatic t_main_seq();
    logic [31:0] exp [9];
    string tag [9];
    exp[0] = 32'hA000_0001; tag[0] = "R3 word0";
    exp[1] = 32'hA000_0002; tag[1] = "R3 word1";
    exp[2] = 32'hB123_005A; tag[2] = "R5 one-byte operand";
    exp[3] = 32'hC000_0003; tag[3] = "R5 unflagged word";
    exp[4] = 32'hC444_1234; tag[4] = "R4 two-byte operand";
    exp[5] = 32'hE000_003E; tag[5] = "R9 empty seq skipped";
    exp[6] = 32'hE000_003F; tag[6] = "R10 top index";
    exp[7] = 32'hA000_0001; tag[7] = "R10 wrap to 0";
    exp[8] = 32'hD555_00FF; tag[8] = "R6 order kept";
    jump(16'h0000);
    for (int i = 0; i < 9; i++) expect_word(tag[i], exp[i]);
  endtask

  // R7: prefetch limit with idle host
  task automatic t_queue_limit();
    int base;
    jump(16'h0080);
    base = ack_cnt;
    repeat (40) @(negedge clk);
    #1;
    chk(mem_req == 1'b0, "R7 request stops", 32'(mem_req), 32'd0);
    chk(ack_cnt - base == 5, "R7 five held", 32'(ack_cnt - base), 32'd5);
    for (int i = 0; i < 4; i++)
      expect_word("R7 drain order", (i % 2 == 0) ? 32'hA000_0001 : 32'hA000_0002);
  endtask

  // R8: jump mid-sequence
  task automatic t_jump();
    jump(16'h0080);
    expect_word("R8 before jump", 32'hA000_0001);
    jump(16'h0040);
    expect_word("R8 target first", 32'hB123_0077);
    expect_word("R8 target second", 32'hA000_0001);
    expect_word("R8 target third", 32'hA000_0002);
  endtask

  task automatic run_all();
    t_reset_state();
    t_program();
    t_wait_states();
    t_main_seq();
    t_queue_limit();
    t_jump();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h10; mem[1] = 8'h11; mem[2] = 8'h5A;
    mem[3] = 8'h12; mem[4] = 8'h34; mem[5] = 8'h12;
    mem[6] = 8'h13; mem[7] = 8'h14; mem[8] = 8'h15; mem[9] = 8'hFF;
    mem[8'h40] = 8'h11; mem[8'h41] = 8'h77; mem[8'h42] = 8'h10;
    for (int i = 8'h80; i < 8'hC0; i++) mem[i] = 8'h10;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule